// File: doc/BRIEF.md
# DS3 Transmit Overhead Bit Generator

This block assembles the serial DS3 M-frame on the transmit side. It pulls payload bits one per clock from an upstream source through a ready/valid handshake. Between every 84 payload bits it inserts one overhead bit. The overhead bit is generated internally: framing patterns, payload parity, alarm indication, FEAC and FEBE. An external overhead port can replace any internally generated overhead bit.

Each emitted line bit comes with a valid flag, an overhead marker and a frame-start strobe, so the line side knows where it is in the frame. Two overhead flavours are supported: M23, and C-bit parity. They differ only in what the 21 C-bit positions carry. If the upstream source stalls on a payload slot, the frame position holds and no line bit is emitted for that cycle.

Top module: `ds3_tx_oh_insert`

## Requirements
- R1: A frame is 4760 line bits long: 7 subframes of 8 blocks. Each block is one overhead bit followed by 84 payload bits. `ohMark` is high on exactly the overhead bits. `frameStart` is high on the first overhead bit of each frame. Frames follow each other without a gap.
- R2: `payReady` is low in every overhead slot and high in every payload slot. A payload bit accepted when `payValid && payReady` appears on `lineBit` with `lineValid` high on the next cycle, in acceptance order. A payload slot with `payValid` low emits nothing (`lineValid` low next cycle), and the frame position holds.
- R3: In every subframe, the overhead bits of blocks 2, 4, 6 and 8 (the framing bits) carry 1, 0, 0, 1 in that order.
- R4: The first overhead bit of subframes 5, 6 and 7 carries 0, 1, 0 in that order.
- R5: The first overhead bit of subframes 3 and 4 carries the XOR of all payload bits of the previous frame. In the first frame after reset it carries 0.
- R6: The first overhead bit of subframes 1 and 2 is 0 while any of `losIn`, `lofIn` or `aisIn` is high. Otherwise it equals `xSoft`.
- R7: With `modeCbit` low, the overhead bits of blocks 3, 5 and 7 (the C-bits) are 0 in every subframe.
- R8: With `modeCbit` high, the C-bit of block 7 in subframe 1 carries `feacIn` when `feacEn` is high. It carries 1 when `feacEn` is low.
- R9: With `modeCbit` high, the C-bits of subframe 4 (blocks 3, 5, 7) carry bits 2, 1, 0 of a 3-bit code. That code is `febeSwVal` when `febeSwEn` is high. Otherwise it is 3'b000 when `febeErr` is high, else 3'b111.
- R10: With `modeCbit` high, the C-bits of subframe 3 carry the same previous-frame parity as R5. The C-bits of blocks 3 and 5 in subframe 1, and all C-bits of subframes 2, 5, 6 and 7, carry 1.
- R11: While `extOhEn` is high in an overhead slot, that overhead bit is `extOhData` instead of the internal value. Payload bits are unaffected.
- R12: During reset, `lineValid`, `ohMark`, `frameStart` and `payReady` are low. The first bit after reset is the first overhead bit of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCbit | input | 1 | 1 = C-bit parity overhead, 0 = M23 overhead |
| payData | input | 1 | Payload bit from upstream |
| payValid | input | 1 | Payload bit valid |
| payReady | output | 1 | Block accepts a payload bit this cycle |
| xSoft | input | 1 | Alarm-indication bit value when no defect |
| losIn | input | 1 | Receive loss-of-signal defect |
| lofIn | input | 1 | Receive loss/out-of-frame defect |
| aisIn | input | 1 | Receive alarm indication signal defect |
| feacEn | input | 1 | FEAC source active |
| feacIn | input | 1 | Serial FEAC bit |
| febeErr | input | 1 | Receive side reports parity or framing errors |
| febeSwEn | input | 1 | Use the software FEBE code |
| febeSwVal | input | 3 | Software FEBE code |
| extOhEn | input | 1 | Replace the current overhead bit |
| extOhData | input | 1 | Replacement overhead bit |
| lineBit | output | 1 | Serial line bit |
| lineValid | output | 1 | `lineBit` holds a frame bit |
| frameStart | output | 1 | First bit of a frame |
| ohMark | output | 1 | `lineBit` is an overhead bit |

## Verification
Every line bit is registered once, so an overhead or payload decision made at the acceptance edge shows on the line one cycle later. The monitor samples the outputs on the falling edge and tags each bit by the position it tracks from `frameStart`. Parity results are due one full frame later. The bench therefore holds each configuration for two frames and checks only the second, complete frame, comparing its parity bits with the XOR it accumulated over the frame before. A stalled payload slot must leave the next cycle's `lineValid` low; the gap scenario checks this by counting idle cycles and the frame length.

// File: rtl/ds3tx_pkg.sv
package ds3tx_pkg;
  localparam int SUBFRAMES     = 7;
  localparam int BLOCKS        = 8;
  localparam int PAY_PER_BLOCK = 84;
  localparam int X_SUBS        = 2;
  localparam int P_SUBS        = 2;
  localparam int BLOCK_LEN     = PAY_PER_BLOCK + 1;
  localparam int SUB_W         = $clog2(SUBFRAMES);
  localparam int BLK_W         = $clog2(BLOCKS);
  localparam int BIT_W         = $clog2(BLOCK_LEN);
  localparam int IDX_W         = BLK_W - 1;

  typedef enum logic [2:0] {
    OH_NONE, OH_X, OH_P, OH_M, OH_F, OH_C
  } ohKind_t;

  typedef struct packed {
    logic             advance;
    logic             ohSlot;
    logic             frameFirst;
    logic             frameEnd;
    ohKind_t          kind;
    logic [SUB_W-1:0] sub;
    logic [IDX_W-1:0] slotIdx;
  } ctlStrb_t;
endpackage

// File: rtl/ds3tx_ctl.sv
module ds3tx_ctl
  import ds3tx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     payValid,
  output logic     payReady,
  output ctlStrb_t strb
);
  logic [SUB_W-1:0] subQ;
  logic [BLK_W-1:0] blkQ;
  logic [BIT_W-1:0] bitQ;
  logic ohSlot, advance, endBlk, endSub, endFrame;
  ohKind_t kind;

  assign ohSlot   = (bitQ == '0);
  assign advance  = ohSlot | payValid;
  assign payReady = rstN & ~ohSlot;
  assign endBlk   = (bitQ == BIT_W'(PAY_PER_BLOCK));
  assign endSub   = endBlk && (blkQ == BLK_W'(BLOCKS - 1));
  assign endFrame = endSub && (subQ == SUB_W'(SUBFRAMES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subQ <= '0;
      blkQ <= '0;
      bitQ <= '0;
    end else if (advance) begin
      if (endBlk) begin
        bitQ <= '0;
        if (endSub) begin
          blkQ <= '0;
          subQ <= endFrame ? '0 : subQ + 1'b1;
        end else begin
          blkQ <= blkQ + 1'b1;
        end
      end else begin
        bitQ <= bitQ + 1'b1;
      end
    end
  end

  always_comb begin
    if (!ohSlot)                                kind = OH_NONE;
    else if (blkQ == '0) begin
      if (subQ < SUB_W'(X_SUBS))                kind = OH_X;
      else if (subQ < SUB_W'(X_SUBS + P_SUBS))  kind = OH_P;
      else                                      kind = OH_M;
    end
    else if (blkQ[0])                           kind = OH_F;
    else                                        kind = OH_C;
  end

  always_comb begin
    strb.advance    = advance;
    strb.ohSlot     = ohSlot;
    strb.frameFirst = ohSlot && (subQ == '0) && (blkQ == '0);
    strb.frameEnd   = advance && endFrame;
    strb.kind       = kind;
    strb.sub        = subQ;
    strb.slotIdx    = blkQ[BLK_W-1:1];
  end

  // position holds while the upstream stalls a payload slot
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !advance |=> $stable({subQ, blkQ, bitQ}));

  // after the last payload bit the next slot is the frame's first overhead bit
  assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (advance && endFrame) |=> (subQ == '0 && blkQ == '0 && bitQ == '0));
endmodule

// File: rtl/ds3tx_dp.sv
module ds3tx_dp
  import ds3tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrb_t   strb,
  input  logic       payData,
  input  logic       modeCbit,
  input  logic       xSoft,
  input  logic       losIn,
  input  logic       lofIn,
  input  logic       aisIn,
  input  logic       feacEn,
  input  logic       feacIn,
  input  logic       febeErr,
  input  logic       febeSwEn,
  input  logic [2:0] febeSwVal,
  input  logic       extOhEn,
  input  logic       extOhData,
  output logic       lineBit,
  output logic       lineValid,
  output logic       frameStart,
  output logic       ohMark
);
  logic accParQ, prevParQ;
  logic defect, intBit, ohBit, cBit;
  logic [2:0] febeCode;

  assign defect   = losIn | lofIn | aisIn;
  assign febeCode = febeSwEn ? febeSwVal : (febeErr ? 3'b000 : 3'b111);

  // payload parity of the running frame and of the frame before it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      accParQ  <= 1'b0;
      prevParQ <= 1'b0;
    end else if (strb.advance && !strb.ohSlot) begin
      if (strb.frameEnd) begin
        prevParQ <= accParQ ^ payData;
        accParQ  <= 1'b0;
      end else begin
        accParQ  <= accParQ ^ payData;
      end
    end
  end

  // C-bit content in parity mode, chosen by subframe and slot
  always_comb begin
    cBit = 1'b1;
    if (!modeCbit) begin
      cBit = 1'b0;
    end else begin
      case (strb.sub)
        SUB_W'(0): cBit = (strb.slotIdx == IDX_W'(3)) ? (feacEn ? feacIn : 1'b1) : 1'b1;
        SUB_W'(2): cBit = prevParQ;
        SUB_W'(3): cBit = febeCode[IDX_W'(3) - strb.slotIdx];
        default:   cBit = 1'b1;
      endcase
    end
  end

  always_comb begin
    case (strb.kind)
      OH_X:    intBit = defect ? 1'b0 : xSoft;
      OH_P:    intBit = prevParQ;
      OH_M:    intBit = (strb.sub == SUB_W'(SUBFRAMES - 2));
      OH_F:    intBit = (strb.slotIdx == '0) || (strb.slotIdx == IDX_W'(3));
      OH_C:    intBit = cBit;
      default: intBit = 1'b0;
    endcase
    ohBit = extOhEn ? extOhData : intBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBit    <= 1'b0;
      lineValid  <= 1'b0;
      frameStart <= 1'b0;
      ohMark     <= 1'b0;
    end else begin
      lineValid  <= strb.advance;
      frameStart <= strb.advance && strb.frameFirst;
      ohMark     <= strb.advance && strb.ohSlot;
      if (strb.advance) lineBit <= strb.ohSlot ? ohBit : payData;
    end
  end

  assert_ext_override_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.ohSlot && extOhEn) |=> (ohMark && lineBit == $past(extOhData)));

  assert_x_defect_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && strb.kind == OH_X && defect && !extOhEn) |=> (ohMark && !lineBit));

  assert_payload_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.ohSlot) |=> (lineValid && !ohMark && lineBit == $past(payData)));

  assert_start_is_oh_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (ohMark && lineValid));
endmodule

// File: rtl/ds3_tx_oh_insert.sv
module ds3_tx_oh_insert
  import ds3tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeCbit,
  input  logic       payData,
  input  logic       payValid,
  output logic       payReady,
  input  logic       xSoft,
  input  logic       losIn,
  input  logic       lofIn,
  input  logic       aisIn,
  input  logic       feacEn,
  input  logic       feacIn,
  input  logic       febeErr,
  input  logic       febeSwEn,
  input  logic [2:0] febeSwVal,
  input  logic       extOhEn,
  input  logic       extOhData,
  output logic       lineBit,
  output logic       lineValid,
  output logic       frameStart,
  output logic       ohMark
);
  ctlStrb_t strb;

  ds3tx_ctl ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .payValid (payValid),
    .payReady (payReady),
    .strb     (strb)
  );

  ds3tx_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .payData    (payData),
    .modeCbit   (modeCbit),
    .xSoft      (xSoft),
    .losIn      (losIn),
    .lofIn      (lofIn),
    .aisIn      (aisIn),
    .feacEn     (feacEn),
    .feacIn     (feacIn),
    .febeErr    (febeErr),
    .febeSwEn   (febeSwEn),
    .febeSwVal  (febeSwVal),
    .extOhEn    (extOhEn),
    .extOhData  (extOhData),
    .lineBit    (lineBit),
    .lineValid  (lineValid),
    .frameStart (frameStart),
    .ohMark     (ohMark)
  );
endmodule

// File: tb/ds3_tx_oh_insert_tb.sv
module ds3_tx_oh_insert_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME_LEN  = 4760;
  localparam int BLK_LEN    = 85;
  localparam int WATCHDOG   = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeCbit = 1'b0, xSoft = 1'b1, losIn = 1'b0, lofIn = 1'b0, aisIn = 1'b0;
  logic feacEn = 1'b0, feacIn = 1'b0, febeErr = 1'b0, febeSwEn = 1'b0;
  logic [2:0] febeSwVal = 3'b000;
  logic extOhEn = 1'b0, extOhData = 1'b0;
  logic gapMode = 1'b0;
  logic payData, payValid, payReady, lineBit, lineValid, frameStart, ohMark;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ds3_tx_oh_insert dut_i (
    .clk(clk), .rstN(rstN), .modeCbit(modeCbit), .payData(payData),
    .payValid(payValid), .payReady(payReady), .xSoft(xSoft), .losIn(losIn),
    .lofIn(lofIn), .aisIn(aisIn), .feacEn(feacEn), .feacIn(feacIn),
    .febeErr(febeErr), .febeSwEn(febeSwEn), .febeSwVal(febeSwVal),
    .extOhEn(extOhEn), .extOhData(extOhData), .lineBit(lineBit),
    .lineValid(lineValid), .frameStart(frameStart), .ohMark(ohMark)
  );

  function automatic logic [14:0] lfsrStep(logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  // payload source
  logic [14:0] genLfsr;
  logic [1:0]  gapCnt;
  assign payData  = genLfsr[0];
  assign payValid = !gapMode || (gapCnt != 2'd0);
  always @(posedge clk) begin
    if (!rstN) begin
      genLfsr <= 15'h1ACE;
      gapCnt  <= 2'd0;
    end else begin
      gapCnt <= gapCnt + 2'd1;
      if (payValid && payReady) genLfsr <= lfsrStep(genLfsr);
    end
  end

  // output monitor: tracks the frame position from frameStart
  logic [14:0] monLfsr;
  logic        started = 1'b0;
  int pos = 0, posErr = 0, payErr = 0, idleCnt = 0;
  logic par = 1'b0, curPrev = 1'b0;
  logic [55:0] ohCur;
  logic [55:0] recOh;
  logic recPrev;
  int recLen, recPosErr, recPayErr, recIdle;
  event frameDone;

  always @(negedge clk) begin
    if (!rstN) begin
      monLfsr = 15'h1ACE;
      started = 1'b0;
      pos = 0; posErr = 0; payErr = 0; idleCnt = 0;
      par = 1'b0; curPrev = 1'b0;
    end else if (!lineValid) begin
      if (started) idleCnt++;
    end else begin
      if (frameStart) begin
        if (started) begin
          recOh = ohCur; recPrev = curPrev; recLen = pos;
          recPosErr = posErr; recPayErr = payErr; recIdle = idleCnt;
          curPrev = par;
          -> frameDone;
        end
        started = 1'b1;
        pos = 0; posErr = 0; payErr = 0; idleCnt = 0; par = 1'b0;
      end
      if (started) begin
        if (ohMark) begin
          if (pos % BLK_LEN != 0 || pos >= FRAME_LEN) posErr++;
          else ohCur[pos / BLK_LEN] = lineBit;
        end else begin
          if (pos % BLK_LEN == 0) posErr++;
          if (lineBit !== monLfsr[0]) payErr++;
          par = par ^ lineBit;
          monLfsr = lfsrStep(monLfsr);
        end
        pos++;
      end
    end
  end

  task automatic chkEq(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic expOh(int s, int b, logic pp);
    logic [2:0] febe;
    int c;
    febe = febeSwEn ? febeSwVal : (febeErr ? 3'b000 : 3'b111);
    if (extOhEn) return extOhData;
    if (b == 0) begin
      if (s < 2) return (losIn || lofIn || aisIn) ? 1'b0 : xSoft;
      if (s < 4) return pp;
      return (s == 5);
    end
    if (b % 2 == 1) return (b == 1 || b == 7);
    c = b / 2 - 1;
    if (!modeCbit) return 1'b0;
    case (s)
      0:       return (c == 2) ? (feacEn ? feacIn : 1'b1) : 1'b1;
      2:       return pp;
      3:       return febe[2 - c];
      default: return 1'b1;
    endcase
  endfunction

  task automatic checkOh(string tag, int s, int b);
    chkEq(tag, $sformatf("overhead sub%0d blk%0d", s + 1, b + 1),
          int'(recOh[s * 8 + b]), int'(expOh(s, b, recPrev)));
  endtask

  task automatic checkShape(string tag);
    chkEq(tag, "frame length", recLen, FRAME_LEN);
    chkEq(tag, "overhead position errors", recPosErr, 0);
    chkEq("R2", "payload order errors", recPayErr, 0);
  endtask

  task automatic settle();
    @(frameDone);
    @(frameDone);
    #1;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    chkEq("R12", "lineValid in reset", int'(lineValid), 0);
    chkEq("R12", "ohMark in reset", int'(ohMark), 0);
    chkEq("R12", "frameStart in reset", int'(frameStart), 0);
    chkEq("R12", "payReady in reset", int'(payReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R12", "first bit is frame start", int'(frameStart && ohMark), 1);
  endtask

  task automatic testFirstFrame();
    @(frameDone);
    #1;
    chkEq("R5", "first-frame P sub3", int'(recOh[2 * 8]), 0);
    chkEq("R5", "first-frame P sub4", int'(recOh[3 * 8]), 0);
    checkShape("R1");
  endtask

  task automatic testM23();
    modeCbit = 1'b0; xSoft = 1'b1;
    settle();
    checkShape("R1");
    for (int s = 0; s < 7; s++) begin
      for (int b = 1; b < 8; b += 2) checkOh("R3", s, b);
      for (int b = 2; b < 8; b += 2) checkOh("R7", s, b);
    end
    for (int s = 4; s < 7; s++) checkOh("R4", s, 0);
    checkOh("R5", 2, 0);
    checkOh("R5", 3, 0);
    chkEq("R5", "P equals previous parity", int'(recOh[16]), int'(recPrev));
    checkOh("R6", 0, 0);
    checkOh("R6", 1, 0);
  endtask

  task automatic testDefects();
    for (int d = 0; d < 3; d++) begin
      losIn = (d == 0); lofIn = (d == 1); aisIn = (d == 2);
      settle();
      checkOh("R6", 0, 0);
      checkOh("R6", 1, 0);
      chkEq("R6", $sformatf("X low under defect %0d", d), int'(recOh[0] | recOh[8]), 0);
    end
    losIn = 1'b0; lofIn = 1'b0; aisIn = 1'b0; xSoft = 1'b0;
    settle();
    chkEq("R6", "X follows software value 0", int'(recOh[0] | recOh[8]), 0);
    xSoft = 1'b1;
  endtask

  task automatic testCbitFeac();
    modeCbit = 1'b1; feacEn = 1'b1; feacIn = 1'b0; febeErr = 1'b0;
    settle();
    checkShape("R1");
    checkOh("R8", 0, 6);
    chkEq("R8", "FEAC carries input 0", int'(recOh[6]), 0);
    for (int b = 2; b < 8; b += 2) checkOh("R9", 3, b);
    chkEq("R9", "FEBE clean 111", int'({recOh[26], recOh[28], recOh[30]}), 7);
    for (int s = 0; s < 7; s++)
      for (int b = 2; b < 8; b += 2) checkOh("R10", s, b);
    chkEq("R10", "CP equals P", int'(recOh[18]), int'(recOh[16]));
  endtask

  task automatic testCbitFebe();
    modeCbit = 1'b1; feacEn = 1'b0; febeErr = 1'b1; febeSwEn = 1'b0;
    settle();
    chkEq("R8", "FEAC idle is 1", int'(recOh[6]), 1);
    chkEq("R9", "FEBE on error", int'({recOh[26], recOh[28], recOh[30]}), 0);
    febeSwEn = 1'b1; febeSwVal = 3'b010;
    settle();
    chkEq("R9", "FEBE software code", int'({recOh[26], recOh[28], recOh[30]}), 2);
    febeSwEn = 1'b0; febeErr = 1'b0;
  endtask

  task automatic testExternal();
    modeCbit = 1'b1; extOhEn = 1'b1; extOhData = 1'b0;
    settle();
    chkEq("R11", "all overhead replaced by 0", int'(recOh == 56'd0), 1);
    checkShape("R11");
    extOhData = 1'b1;
    settle();
    chkEq("R11", "all overhead replaced by 1", int'(&recOh), 1);
    extOhEn = 1'b0;
  endtask

  task automatic testGaps();
    modeCbit = 1'b0; gapMode = 1'b1;
    settle();
    checkShape("R2");
    chkEq("R2", "stalled slots emitted nothing", int'(recIdle > 0), 1);
    checkOh("R5", 2, 0);
    checkOh("R3", 5, 7);
    gapMode = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    testReset();
    testFirstFrame();
    testM23();
    testDefects();
    testCbitFeac();
    testCbitFebe();
    testExternal();
    testGaps();
    finishRun();
  end
endmodule